// File: doc/BRIEF.md
# Work-RAM Arbiter with Exclusive-Access Monitor

This block sits between a sound engine's load/store unit and a shared 256-entry, 16-bit work RAM that a host system also reads and writes. Every access is one halfword, and the RAM is addressed in halfwords, so neighbouring 16-bit words differ by one in address. The engine always wins the RAM. A host request that meets an engine request is held off through a valid/ready handshake until the engine leaves the RAM free.

The block also keeps one exclusive reservation so that the engine can do a race-free read-modify-write on a variable that the host may overwrite at any time. A linked load reads like a plain load and also records its address and arms the reservation. A host write request to the recorded address breaks the reservation. Any conditional store also ends it. A conditional store writes only while the reservation is held, and is dropped otherwise. The engine gets no success or failure indication.

The reservation is a two-state machine, `RSV_OPEN` and `RSV_HELD`. Its transitions are `arm` (OPEN to HELD on a linked load with no colliding host write), `rearm` (HELD to HELD on a new linked load), `consume` (HELD to OPEN on any conditional store), and `break` (HELD to OPEN on a host write to the watched address). A second machine tracks who owns the read data returned in the next cycle. Its states are `RD_NONE`, `RD_ENG` and `RD_HOST`, and it moves to whichever side was granted a read in the current cycle.

Top module: `xmon_wram`

## Requirements
- R1: `host_ready` is low in every cycle where `eng_req` is high, and high otherwise. A host access takes effect only in a cycle where `host_valid` and `host_ready` are both high.
- R2: An engine load (`eng_op` = 2'b00) returns the word at `eng_addr` on `eng_rdata`, with `eng_rvalid` high, in the cycle after the request. Addresses count halfwords.
- R3: An engine store (`eng_op` = 2'b01) writes `eng_wdata` to `eng_addr` unconditionally.
- R4: A linked load (`eng_op` = 2'b10) returns data like a load, records `eng_addr` and arms the reservation.
- R5: A conditional store (`eng_op` = 2'b11) made while the reservation is held writes its data and then leaves the reservation open. A second conditional store is therefore dropped.
- R6: A conditional store made while the reservation is open leaves the RAM unchanged.
- R7: A host write presented to the recorded address opens the reservation, whether or not that write is accepted.
- R8: A host write to any other address leaves the reservation as it was.
- R9: A new linked load replaces the recorded address and arms again, so only the newest address is watched.
- R10: When a conditional store and a host write to the recorded address are presented in the same cycle, the store is dropped. The host write completes in a later cycle, once the engine is idle.
- R11: An accepted host read (`host_we` = 0) returns the word on `host_rdata`, with `host_rvalid` high, in the following cycle.
- R12: After reset both read-valid outputs are low and the reservation is open, so a conditional store made before any linked load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_req | input | 1 | Engine access request for this cycle |
| eng_op | input | 2 | 00 load, 01 store, 10 linked load, 11 conditional store |
| eng_addr | input | 8 | Engine halfword address |
| eng_wdata | input | 16 | Engine store data |
| eng_rdata | output | 16 | Read data, valid when eng_rvalid |
| eng_rvalid | output | 1 | Engine read data valid (one cycle after the load) |
| host_valid | input | 1 | Host request valid |
| host_we | input | 1 | Host request is a write |
| host_addr | input | 8 | Host halfword address |
| host_wdata | input | 16 | Host write data |
| host_ready | output | 1 | Host request accepted this cycle |
| host_rdata | output | 16 | Read data, valid when host_rvalid |
| host_rvalid | output | 1 | Host read data valid (one cycle after acceptance) |

## Verification
The bench targets the collision cases. The first is a conditional store meeting a host write to the watched word in the same cycle: a design that let the store through would lose the host value, because the host write would later land on top of a modify computed from stale data. The second is a host write to a neighbouring word, which a design comparing too few address bits would treat as a break, dropping a store that should succeed. The third is a linked load that moves the watch to a new word, where keeping the old address would break on the wrong host write. A random phase over four addresses mixes all of these with stalled host reads. A reference model checks every read result against its own memory copy, so a dropped or wrongly performed store shows up as a data mismatch.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
    typedef enum logic [1:0] {
        OP_LD  = 2'b00,
        OP_ST  = 2'b01,
        OP_LDL = 2'b10,
        OP_STC = 2'b11
    } eng_op_e;

    typedef enum logic {
        RSV_OPEN = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_e;

    typedef enum logic [1:0] {
        RD_NONE = 2'b00,
        RD_ENG  = 2'b01,
        RD_HOST = 2'b10
    } rd_owner_e;
endpackage

// File: rtl/xmon_ram.sv
module xmon_ram #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/xmon_rsv.sv
module xmon_rsv
    import xmon_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eng_req,
    input  eng_op_e       eng_op,
    input  logic [AW-1:0] eng_addr,
    input  logic          host_valid,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    output logic          stc_ok
);
    rsv_state_e    state_q, state_d;
    logic [AW-1:0] held_addr_q;
    logic [AW-1:0] watch_addr;
    logic          is_ldl, is_stc, host_hit;

    always_comb begin
        is_ldl     = eng_req && (eng_op == OP_LDL);
        is_stc     = eng_req && (eng_op == OP_STC);
        watch_addr = is_ldl ? eng_addr : held_addr_q;
        host_hit   = host_valid && host_we && (host_addr == watch_addr);
    end

    // next-state: arm / rearm / consume / break
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RSV_OPEN: begin
                if (is_ldl && !host_hit) state_d = RSV_HELD;
            end
            RSV_HELD: begin
                if (is_ldl)        state_d = host_hit ? RSV_OPEN : RSV_HELD;
                else if (is_stc)   state_d = RSV_OPEN;
                else if (host_hit) state_d = RSV_OPEN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= RSV_OPEN;
            held_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (is_ldl) held_addr_q <= eng_addr;
        end
    end

    // outputs: host write check wins over the store in the same cycle
    always_comb begin
        stc_ok = 1'b0;
        unique case (state_q)
            RSV_OPEN: stc_ok = 1'b0;
            RSV_HELD: stc_ok = is_stc && !host_hit;
        endcase
    end

    p_ldl_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ldl && !host_hit) |=> (state_q == RSV_HELD));
    p_stc_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_stc |=> (state_q == RSV_OPEN));
    p_open_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RSV_OPEN) |-> !stc_ok);
    p_host_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RSV_HELD && !is_ldl && host_valid && host_we
         && host_addr == held_addr_q) |=> (state_q == RSV_OPEN));
endmodule

// File: rtl/xmon_arb.sv
module xmon_arb
    import xmon_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eng_req,
    input  eng_op_e       eng_op,
    input  logic [AW-1:0] eng_addr,
    input  logic [DW-1:0] eng_wdata,
    input  logic          stc_ok,
    input  logic          host_valid,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_ready,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_re,
    output logic [AW-1:0] ram_raddr,
    output logic          eng_rvalid,
    output logic          host_rvalid
);
    rd_owner_e owner_q, owner_d;
    logic      eng_rd, eng_wr, host_go;

    always_comb begin
        host_ready = !eng_req;
        host_go    = host_valid && !eng_req;
        eng_rd     = eng_req && (eng_op == OP_LD || eng_op == OP_LDL);
        eng_wr     = eng_req && (eng_op == OP_ST || (eng_op == OP_STC && stc_ok));

        ram_we    = eng_wr || (host_go && host_we);
        ram_waddr = eng_req ? eng_addr  : host_addr;
        ram_wdata = eng_req ? eng_wdata : host_wdata;
        ram_re    = eng_rd || (host_go && !host_we);
        ram_raddr = eng_req ? eng_addr  : host_addr;
    end

    always_comb begin
        owner_d = RD_NONE;
        if (eng_rd)                   owner_d = RD_ENG;
        else if (host_go && !host_we) owner_d = RD_HOST;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= RD_NONE;
        else        owner_q <= owner_d;
    end

    always_comb begin
        eng_rvalid  = 1'b0;
        host_rvalid = 1'b0;
        unique case (owner_q)
            RD_NONE: ;
            RD_ENG:  eng_rvalid  = 1'b1;
            RD_HOST: host_rvalid = 1'b1;
            default: ;
        endcase
    end

    p_eng_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_op[0]) |=> (eng_rvalid && !host_rvalid));
    p_host_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ready && !host_we) |=> host_rvalid);
    p_no_host_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_op[0]) |-> !ram_we);
endmodule

// File: rtl/xmon_wram.sv
module xmon_wram
    import xmon_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_req,
    input  logic [1:0]        eng_op,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic [DATA_W-1:0] eng_rdata,
    output logic              eng_rvalid,
    input  logic              host_valid,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid
);
    eng_op_e           op;
    logic              stc_ok, ram_we, ram_re;
    logic [ADDR_W-1:0] ram_waddr, ram_raddr;
    logic [DATA_W-1:0] ram_wdata, ram_rdata;

    assign op = eng_op_e'(eng_op);

    xmon_rsv #(.AW(ADDR_W)) rsv_i (
        .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_op(op),
        .eng_addr(eng_addr), .host_valid(host_valid), .host_we(host_we),
        .host_addr(host_addr), .stc_ok(stc_ok)
    );

    xmon_arb #(.AW(ADDR_W), .DW(DATA_W)) arb_i (
        .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .eng_op(op),
        .eng_addr(eng_addr), .eng_wdata(eng_wdata), .stc_ok(stc_ok),
        .host_valid(host_valid), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ready(host_ready),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .ram_re(ram_re), .ram_raddr(ram_raddr),
        .eng_rvalid(eng_rvalid), .host_rvalid(host_rvalid)
    );

    xmon_ram #(.AW(ADDR_W), .DW(DATA_W)) ram_i (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
    );

    assign eng_rdata  = ram_rdata;
    assign host_rdata = ram_rdata;

    p_reset_quiet_r12: assert property (@(posedge clk)
        !rst_n |=> (!eng_rvalid && !host_rvalid));
endmodule

// File: tb/xmon_wram_tb.sv
module xmon_wram_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eng_req = 1'b0;
    logic [1:0]  eng_op = 2'b00;
    logic [7:0]  eng_addr = '0;
    logic [15:0] eng_wdata = '0;
    logic [15:0] eng_rdata;
    logic        eng_rvalid;
    logic        host_valid = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ready;
    logic [15:0] host_rdata;
    logic        host_rvalid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [15:0] m_mem [256];
    bit          m_armed = 1'b0;
    logic [7:0]  m_laddr = '0;

    always #4 clk = ~clk;

    xmon_wram dut_i (.*);

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // one clock: drive, check ready, update model, check registered outputs
    task automatic cyc(input bit rq, input logic [1:0] op, input logic [7:0] a, input logic [15:0] wd,
                       input bit hv, input bit hwe, input logic [7:0] ha, input logic [15:0] hwd,
                       input string tag);
        logic [7:0]  watch;
        bit          hhit, ok, ev, hvv;
        logic [15:0] ed, hd;
        @(negedge clk);
        eng_req = rq; eng_op = op; eng_addr = a; eng_wdata = wd;
        host_valid = hv; host_we = hwe; host_addr = ha; host_wdata = hwd;
        #1;
        chk(tag, "host_ready(R1)", {15'd0, host_ready}, {15'd0, !rq});
        watch = (rq && op == 2'b10) ? a : m_laddr;
        hhit  = hv && hwe && (ha == watch);
        ok    = rq && op == 2'b11 && m_armed && !hhit;
        ev    = rq && !op[0];
        ed    = m_mem[a];
        hvv   = !rq && hv && !hwe;
        hd    = m_mem[ha];
        if (rq && (op == 2'b01 || ok)) m_mem[a] = wd;
        else if (!rq && hv && hwe)     m_mem[ha] = hwd;
        if (rq && op == 2'b10) begin
            m_armed = !hhit;
            m_laddr = a;
        end else if (rq && op == 2'b11) m_armed = 1'b0;
        else if (hhit)                   m_armed = 1'b0;
        @(posedge clk);
        #1;
        chk(tag, "eng_rvalid", {15'd0, eng_rvalid}, {15'd0, ev});
        chk(tag, "host_rvalid", {15'd0, host_rvalid}, {15'd0, hvv});
        if (ev)  chk(tag, "eng_rdata", eng_rdata, ed);
        if (hvv) chk(tag, "host_rdata", host_rdata, hd);
    endtask

    task automatic eng(input logic [1:0] op, input logic [7:0] a, input logic [15:0] wd, input string tag);
        cyc(1'b1, op, a, wd, 1'b0, 1'b0, 8'h00, 16'h0, tag);
    endtask

    task automatic hw(input logic [7:0] a, input logic [15:0] d, input string tag);
        cyc(1'b0, 2'b00, 8'h00, 16'h0, 1'b1, 1'b1, a, d, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R12", "eng_rvalid in reset", {15'd0, eng_rvalid}, 16'd0);
        chk("R12", "host_rvalid in reset", {15'd0, host_rvalid}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 256; i++) hw(8'(i), 16'(i * 16'h0101 + 16'h1000), "R1");

        // R12: conditional store with no prior linked load is dropped
        eng(2'b11, 8'h30, 16'hDEAD, "R12");
        eng(2'b00, 8'h30, 16'h0, "R12");

        // R2 R3: plain store and load, adjacent halfwords
        eng(2'b01, 8'h10, 16'hAAAA, "R3");
        eng(2'b01, 8'h11, 16'hBBBB, "R3");
        eng(2'b00, 8'h10, 16'h0, "R2");
        eng(2'b00, 8'h11, 16'h0, "R2");

        // R4 R5 R6
        eng(2'b10, 8'h20, 16'h0, "R4");
        eng(2'b11, 8'h20, 16'hC0C0, "R5");
        eng(2'b00, 8'h20, 16'h0, "R5");
        eng(2'b11, 8'h20, 16'hD0D0, "R6");
        eng(2'b00, 8'h20, 16'h0, "R6");

        // R7: host write to linked word breaks it
        eng(2'b10, 8'h40, 16'h0, "R7");
        hw(8'h40, 16'h4444, "R7");
        eng(2'b11, 8'h40, 16'hEEEE, "R7");
        eng(2'b00, 8'h40, 16'h0, "R7");

        // R8: host write to neighbouring word leaves it held
        eng(2'b10, 8'h50, 16'h0, "R8");
        hw(8'h51, 16'h5151, "R8");
        eng(2'b11, 8'h50, 16'hE5E5, "R8");
        eng(2'b00, 8'h50, 16'h0, "R8");
        eng(2'b00, 8'h51, 16'h0, "R8");

        // R9: newer linked load moves the watch
        eng(2'b10, 8'h60, 16'h0, "R9");
        eng(2'b10, 8'h61, 16'h0, "R9");
        hw(8'h60, 16'h6060, "R9");
        eng(2'b11, 8'h61, 16'hF1F1, "R9");
        eng(2'b00, 8'h61, 16'h0, "R9");
        eng(2'b10, 8'h62, 16'h0, "R9");
        eng(2'b10, 8'h63, 16'h0, "R9");
        hw(8'h63, 16'h6363, "R9");
        eng(2'b11, 8'h63, 16'hF3F3, "R9");
        eng(2'b00, 8'h63, 16'h0, "R9");

        // R10: same-cycle collision, host write lands afterwards
        eng(2'b10, 8'h70, 16'h0, "R10");
        cyc(1'b1, 2'b11, 8'h70, 16'h9999, 1'b1, 1'b1, 8'h70, 16'h7777, "R10");
        hw(8'h70, 16'h7777, "R10");
        eng(2'b00, 8'h70, 16'h0, "R10");

        // R11: host read, stalled then accepted
        cyc(1'b0, 2'b00, 8'h00, 16'h0, 1'b1, 1'b0, 8'h10, 16'h0, "R11");
        cyc(1'b1, 2'b00, 8'h20, 16'h0, 1'b1, 1'b0, 8'h11, 16'h0, "R11");
        cyc(1'b0, 2'b00, 8'h00, 16'h0, 1'b1, 1'b0, 8'h11, 16'h0, "R11");

        // random mix on a few words
        for (int i = 0; i < 3000; i++) begin
            cyc(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
                16'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                8'($urandom_range(0, 3)), 16'($urandom), "RND");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule